// File: doc/BRIEF.md
# Serial-Controlled Keypad Matrix Scanner with Rotary Knob Status

This block sits between a host processor's serial peripheral bus and a 4-row by 8-column key matrix. Each 16-bit SPI transfer (mode 0, most significant bit first) carries a row-select pattern from the host in its first byte. The block drives the four row lines with that pattern, waits for the matrix to settle, and samples the eight column lines. It returns that sample in the second byte of the same transfer. The host steps a single low row through the matrix, one transfer per row, and locates a pressed key by matching the row it pulled low with the column that reads low.

The first byte shifted back to the host reports a rotary knob with quadrature outputs and a push switch. It gives the switch level, the direction of the most recent knob detent, and a saturating two-bit count of detents taken since the previous transfer began. Debounce and key-code mapping stay in host software. All asynchronous inputs are resynchronised to the system clock, and the serial clock is oversampled, so it must run well below the system clock.

Top module: `keypad_spi_scanner`

## Requirements
- R1: After reset, all four row outputs are high, MISO is low, and the knob step count and direction are zero.
- R2: When the low 4 bits of the first received byte hold exactly one zero, that pattern drives the rows (bit n to row n) from the 8th serial clock rising edge. It holds until a later frame reaches its 8th bit.
- R3: A first byte whose low 4 bits contain zero, two, three or four zeros drives all rows high.
- R4: Bits 7..4 of the first received byte have no effect on the rows.
- R5: The second returned byte carries the column inputs, column 7 first. They are sampled SETTLE_CLKS + SYNC_STAGES system clocks after the rows change. A column reads 0 when a key at the low row is pressed.
- R6: The first returned byte is {0000, switch pressed (enc_sw_n low), direction, count[1:0]}, captured when chip select falls.
- R7: The step count saturates at 3.
- R8: Capturing the status for a frame clears the step count. A step in the same cycle counts toward the next frame.
- R9: A single-line change of {enc_a, enc_b} along 00→01→11→10→00 is a step with direction 1. The reverse order is a step with direction 0. A change of both lines at once is ignored.
- R10: A frame in which chip select rises before the 8th bit leaves the rows unchanged.
- R11: MISO is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_miso | output | 1 | Serial data to host |
| row_drv | output | 4 | Row drive lines, one low at a time |
| col_in | input | 8 | Column sense lines, low when a key connects them to a low row |
| enc_a | input | 1 | Knob quadrature channel A |
| enc_b | input | 1 | Knob quadrature channel B |
| enc_sw_n | input | 1 | Knob push switch, low when pressed |

## Verification
The embedded properties watch, on every cycle, that at most one row is ever low and that the rows move only on an accepted byte boundary. They also check that the step count sticks at three, that it clears on a status capture, that a two-line knob jump never counts, and that MISO stays low while deselected. The column contents of a frame, the mapping of the status bits onto MISO, the masking of the upper pattern bits and the survival of the rows through an aborted frame can only be shown by the bench. The bench runs whole transfers against a modelled key matrix and a scripted knob.

// File: rtl/kps_pkg.sv
package kps_pkg;

    localparam int ROWS      = 4;
    localparam int COLS      = 8;
    localparam int BYTE_BITS = 8;
    localparam int FRAME_BITS = 2 * BYTE_BITS;
    localparam int IDX_W     = $clog2(FRAME_BITS);
    localparam int RXC_W     = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic       sw_pressed;
        logic       dir;
        logic [1:0] cnt;
    } enc_stat_t;

    typedef struct packed {
        logic start;
        logic rise;
        logic fall;
    } spi_evt_t;

    // Pass a pattern with exactly one low bit, otherwise release every row.
    function automatic logic [ROWS-1:0] row_gate(input logic [ROWS-1:0] p);
        return ($countones(~p) == 1) ? p : {ROWS{1'b1}};
    endfunction

    // True when exactly one of the two quadrature lines changed.
    function automatic logic single_change(input logic [1:0] prev, input logic [1:0] cur);
        return ^(prev ^ cur);
    endfunction

    // {a,b} ordering: 1 along 00->01->11->10, 0 along the reverse.
    function automatic logic step_dir(input logic [1:0] prev, input logic [1:0] cur);
        return prev[1] ^ cur[0];
    endfunction

endpackage

// File: rtl/kps_sync.sv
module kps_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/kps_quad.sv
module kps_quad
    import kps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       a_s,
    input  logic       b_s,
    input  logic       clr,
    output logic       dir,
    output logic [1:0] cnt
);
    logic [1:0] prev_ab;
    logic       prev_v;
    logic [1:0] cur_ab;
    logic       step;

    assign cur_ab = {a_s, b_s};
    assign step   = prev_v && single_change(prev_ab, cur_ab);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ab <= 2'b00;
            prev_v  <= 1'b0;
            dir     <= 1'b0;
            cnt     <= 2'd0;
        end else begin
            prev_ab <= cur_ab;
            prev_v  <= 1'b1;
            if (step) dir <= step_dir(prev_ab, cur_ab);
            if (clr)
                cnt <= {1'b0, step};
            else if (step && cnt != 2'd3)
                cnt <= cnt + 2'd1;
        end
    end

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (cnt == 2'd3 && !clr) |=> (cnt == 2'd3)); // R7

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !step) |=> (cnt == 2'd0)); // R8

    AST_NO_STEP_DOUBLE: assert property (@(posedge clk) disable iff (rst)
        (prev_v && (prev_ab ^ cur_ab) == 2'b11 && !clr) |=> $stable(cnt)); // R9
endmodule

// File: rtl/kps_spi_frame.sv
module kps_spi_frame
    import kps_pkg::*;
#(
    parameter int SETTLE_TOTAL = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sck_s,
    input  logic            mosi_s,
    input  logic            csn_s,
    input  enc_stat_t       stat_in,
    input  logic [COLS-1:0] cols_s,
    output logic [ROWS-1:0] row_q,
    output logic            miso,
    output logic            snap
);
    localparam int SC_W = $clog2(SETTLE_TOTAL + 1);

    logic             sck_d, csn_d;
    spi_evt_t         ev;
    logic [RXC_W-1:0] rx_cnt;
    logic [ROWS-2:0]  rx_sh;
    logic [IDX_W-1:0] tx_idx;
    logic [SC_W-1:0]  settle;
    enc_stat_t        stat_q;
    logic [COLS-1:0]  col_q;
    logic             row_load;
    logic [BYTE_BITS-1:0] byte0;

    assign ev.start = csn_d & ~csn_s;
    assign ev.rise  = sck_s & ~sck_d & ~csn_s;
    assign ev.fall  = ~sck_s & sck_d & ~csn_s;
    assign snap     = ev.start;
    assign row_load = ev.rise && (rx_cnt == RXC_W'(BYTE_BITS - 1));
    assign byte0    = {{(BYTE_BITS-4){1'b0}}, stat_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d  <= 1'b0;
            csn_d  <= 1'b1;
            rx_cnt <= '0;
            rx_sh  <= '0;
            tx_idx <= '0;
            settle <= '0;
            stat_q <= '0;
            col_q  <= '1;
            row_q  <= {ROWS{1'b1}};
        end else begin
            sck_d <= sck_s;
            csn_d <= csn_s;
            if (csn_s || ev.start) begin
                rx_cnt <= '0;
                tx_idx <= '0;
            end
            if (ev.start) stat_q <= stat_in;
            if (ev.rise) begin
                rx_sh <= {rx_sh[ROWS-3:0], mosi_s};
                if (rx_cnt != RXC_W'(FRAME_BITS)) rx_cnt <= rx_cnt + 1'b1;
            end
            if (ev.fall) tx_idx <= tx_idx + 1'b1;
            if (row_load) begin
                row_q  <= row_gate({rx_sh, mosi_s});
                settle <= SC_W'(SETTLE_TOTAL);
            end else if (settle != '0) begin
                settle <= settle - 1'b1;
                if (settle == SC_W'(1)) col_q <= cols_s;
            end
        end
    end

    always_comb begin
        if (csn_s)
            miso = 1'b0;
        else if (tx_idx < IDX_W'(BYTE_BITS))
            miso = byte0[3'(BYTE_BITS - 1 - int'(tx_idx))];
        else
            miso = col_q[3'(FRAME_BITS - 1 - int'(tx_idx))];
    end

    AST_ROWS_ONE_LOW_MAX: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~row_q)); // R3

    AST_ROWS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !row_load |=> $stable(row_q)); // R2

    AST_ABORT_RESETS_COUNT: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> (rx_cnt == '0)); // R10
endmodule

// File: rtl/keypad_spi_scanner.sv
module keypad_spi_scanner
    import kps_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CLKS = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            spi_sck,
    input  logic            spi_mosi,
    input  logic            spi_cs_n,
    output logic            spi_miso,
    output logic [ROWS-1:0] row_drv,
    input  logic [COLS-1:0] col_in,
    input  logic            enc_a,
    input  logic            enc_b,
    input  logic            enc_sw_n
);
    localparam int SETTLE_TOTAL = SETTLE_CLKS + SYNC_STAGES;

    logic            sck_s, mosi_s, csn_s;
    logic            a_s, b_s, swn_s;
    logic [COLS-1:0] cols_s;
    logic            snap;
    logic            q_dir;
    logic [1:0]      q_cnt;
    enc_stat_t       stat;

    kps_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_spi_sync (
        .clk(clk), .rst(rst),
        .d({spi_cs_n, spi_sck, spi_mosi}),
        .q({csn_s, sck_s, mosi_s})
    );

    kps_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_enc_sync (
        .clk(clk), .rst(rst),
        .d({enc_a, enc_b, enc_sw_n}),
        .q({a_s, b_s, swn_s})
    );

    kps_sync #(.WIDTH(COLS), .STAGES(SYNC_STAGES), .RST_VAL({COLS{1'b1}})) u_col_sync (
        .clk(clk), .rst(rst), .d(col_in), .q(cols_s)
    );

    kps_quad u_quad (
        .clk(clk), .rst(rst), .a_s(a_s), .b_s(b_s), .clr(snap),
        .dir(q_dir), .cnt(q_cnt)
    );

    always_comb begin
        stat.sw_pressed = ~swn_s;
        stat.dir        = q_dir;
        stat.cnt        = q_cnt;
    end

    kps_spi_frame #(.SETTLE_TOTAL(SETTLE_TOTAL)) u_frame (
        .clk(clk), .rst(rst),
        .sck_s(sck_s), .mosi_s(mosi_s), .csn_s(csn_s),
        .stat_in(stat), .cols_s(cols_s),
        .row_q(row_drv), .miso(spi_miso), .snap(snap)
    );

    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
        csn_s |-> (spi_miso == 1'b0)); // R11
endmodule

// File: tb/tb_keypad_spi_scanner.sv
module tb_keypad_spi_scanner;
    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sck = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
    logic       spi_miso;
    logic [3:0] row_drv;
    logic [7:0] col_in;
    logic       enc_a = 1'b0, enc_b = 1'b0, enc_sw_n = 1'b1;

    logic [7:0] keys [4];
    int checks = 0, errors = 0;

    typedef struct {
        logic [15:0] frame;
        logic [3:0]  rows;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    logic [15:0] rx_last;
    event frame_done;

    logic       m_sw = 1'b0, m_dir = 1'b0;
    logic [1:0] m_cnt = 2'd0;
    logic [3:0] m_rows = 4'hF;

    always #5 clk = ~clk;

    keypad_spi_scanner dut (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .row_drv(row_drv),
        .col_in(col_in), .enc_a(enc_a), .enc_b(enc_b), .enc_sw_n(enc_sw_n)
    );

    // Key matrix model: a pressed key ties its column to its row line.
    always_comb begin
        for (int c = 0; c < 8; c++) begin
            col_in[c] = 1'b1;
            for (int r = 0; r < 4; r++)
                if (!row_drv[r] && keys[r][c]) col_in[c] = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [3:0] exp_rows(input logic [3:0] p);
        int z = 0;
        for (int i = 0; i < 4; i++) if (!p[i]) z++;
        return (z == 1) ? p : 4'hF;
    endfunction

    function automatic logic [7:0] exp_cols(input logic [3:0] r);
        logic [7:0] v = 8'hFF;
        for (int i = 0; i < 4; i++) if (!r[i]) v = ~keys[i];
        return v;
    endfunction

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: predicts the frame, queues it, then runs the transfer.
    task automatic frame(input logic [7:0] b0, input string tag);
        exp_t e;
        logic [15:0] rx;
        m_rows  = exp_rows(b0[3:0]);
        e.frame = {4'b0000, m_sw, m_dir, m_cnt, exp_cols(m_rows)};
        e.rows  = m_rows;
        e.tag   = tag;
        exp_q.push_back(e);
        m_cnt   = 2'd0;
        spi_cs_n = 1'b0;
        spi_mosi = b0[7];
        clocks(HP);
        for (int i = 0; i < 16; i++) begin
            rx[15-i] = spi_miso;
            spi_sck = 1'b1;
            clocks(HP);
            spi_sck = 1'b0;
            spi_mosi = (i < 7) ? b0[6-i] : 1'b0;
            clocks(HP);
        end
        spi_cs_n = 1'b1;
        clocks(HP);
        rx_last = rx;
        -> frame_done;
        clocks(HP);
    endtask

    task automatic partial(input logic [7:0] b0, input int nbits);
        spi_cs_n = 1'b0;
        spi_mosi = b0[7];
        clocks(HP);
        for (int i = 0; i < nbits; i++) begin
            spi_sck = 1'b1;
            clocks(HP);
            spi_sck = 1'b0;
            spi_mosi = b0[6-i];
            clocks(HP);
        end
        spi_cs_n = 1'b1;
        clocks(2 * HP);
    endtask

    task automatic knob(input logic fwd, input int n);
        for (int i = 0; i < n; i++) begin
            case ({enc_a, enc_b})
                2'b00: {enc_a, enc_b} = fwd ? 2'b01 : 2'b10;
                2'b01: {enc_a, enc_b} = fwd ? 2'b11 : 2'b00;
                2'b11: {enc_a, enc_b} = fwd ? 2'b10 : 2'b01;
                default: {enc_a, enc_b} = fwd ? 2'b00 : 2'b11;
            endcase
            m_dir = fwd;
            if (m_cnt != 2'd3) m_cnt = m_cnt + 2'd1;
            clocks(6);
        end
    endtask

    // Monitor: pops each predicted frame and compares with what arrived.
    initial begin
        exp_t e;
        forever begin
            @(frame_done);
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard underflow", 16'h0, 16'h0);
            end else begin
                e = exp_q.pop_front();
                chk(rx_last == e.frame, {e.tag, " frame"}, rx_last, e.frame);
                chk(row_drv == e.rows, {e.tag, " rows"}, {12'h0, row_drv}, {12'h0, e.rows});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        keys[0] = 8'h00;
        keys[1] = 8'h08;
        keys[2] = 8'h81;
        keys[3] = 8'h20;
        clocks(5);
        rst = 1'b0;
        clocks(5);
        // R1 / R11: reset state
        chk(row_drv == 4'hF, "R1 rows after reset", {12'h0, row_drv}, 16'h000F);
        chk(spi_miso == 1'b0, "R11 miso idle", {15'h0, spi_miso}, 16'h0);

        // R2 R5: walk the low row through all four rows
        frame(8'h0E, "R2 R5 row0");
        frame(8'h0D, "R2 R5 row1");
        frame(8'h0B, "R2 R5 row2");
        frame(8'h07, "R2 R5 row3");
        // R4: upper nibble ignored
        frame(8'hAD, "R4 upper bits");
        frame(8'h5B, "R4 upper bits b");
        // R3: malformed patterns
        frame(8'h0F, "R3 no zero");
        frame(8'h00, "R3 all zero");
        frame(8'h05, "R3 two zeros");
        // R9 R6: forward steps and direction
        knob(1'b1, 2);
        frame(8'h0E, "R9 R6 forward");
        // R8: count cleared after being returned
        frame(8'h0D, "R8 cleared");
        // R7: saturation and reverse direction
        knob(1'b0, 5);
        frame(8'h0B, "R7 R9 reverse sat");
        // R6: switch pressed
        enc_sw_n = 1'b0;
        m_sw = 1'b1;
        clocks(6);
        frame(8'h07, "R6 switch");
        enc_sw_n = 1'b1;
        m_sw = 1'b0;
        clocks(6);
        // R9: both lines changing at once is not a step
        {enc_a, enc_b} = ~{enc_a, enc_b};
        clocks(6);
        frame(8'h0E, "R9 double change");
        // R10: aborted frame keeps rows
        frame(8'h0B, "R10 setup");
        partial(8'h0E, 5);
        chk(row_drv == 4'hB, "R10 rows after abort", {12'h0, row_drv}, 16'h000B);
        frame(8'h0D, "R10 next frame");
        chk(spi_miso == 1'b0, "R11 miso idle end", {15'h0, spi_miso}, 16'h0);
        clocks(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule